// File: doc/BRIEF.md
# System Time-Base Counter with Compare Interrupt

This block keeps a free-running 56-bit count that advances once on each clock cycle in which the increment enable input is high. Software sees the count through a read window of two 32-bit words. The upper word pads bits 63:56 with zeros. Each word returns the live count at the moment it is read. No word is latched when the other word is read, so software builds a consistent value by reading high, low and high again, and retrying if the two high reads differ.

A single comparator holds a 64-bit compare value written as two 32-bit words. Only the low 56 bits take part in the comparison. While the comparator is enabled, the count reaching or passing the compare value sets a sticky status flag. The interrupt output is that flag, gated by the enable bit and a mask bit. The flag has no write-one-to-clear: software clears it by writing the enable bit to zero.

The register bus is single-cycle. A write is taken on the clock edge on which the write enable is high. Read data is a combinational decode of the address.

Top module: `sysctr_top`

## Requirements
- R1: After reset, the count, both compare words and the control register read as zero, and irq_o is low.
- R2: The count increases by exactly one on each clock edge with inc_en_i high, and holds its value on every other edge.
- R3: The count is 56 bits wide and wraps from all ones to zero.
- R4: Offset 0x08 returns count bits 31:0. Offset 0x0C returns count bits 55:32 in bits 23:0, with bits 31:24 zero. Each word is the live value at the time of the read, with no latching across the pair.
- R5: Offset 0x20 holds compare bits 31:0 and offset 0x24 holds compare bits 63:32. Both are writable and read back as written.
- R6: The control register at offset 0x2C has enable in bit 0, mask in bit 1 and a read-only status in bit 2. Writes set bits 0 and 1 and cannot change bit 2.
- R7: With enable set, status becomes 1 on the clock edge after the one where count ≥ compare bits 55:0. Compare bits 63:56 do not take part.
- R8: Status stays set, even if the compare value is raised, until a control write with bit 0 equal to 0. That write clears status on its own edge.
- R9: irq_o is high exactly when status is 1, enable is 1 and mask is 0.
- R10: Writes to offsets 0x08 and 0x0C do not change the count. Reads of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inc_en_i | input | 1 | Advance the count on this edge |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, taken on the clock edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Compare interrupt |

## Verification
The bench walks the count across the carry from bit 31 into bit 32 and across the 56-bit wrap, using instances whose reset value is preset. A design that latched one word or mis-carried would return a stale high word or a wrong low word at these points. It checks the exact cycle in which the interrupt rises after the count meets a compare value whose top byte is set. A design that compared 64 bits would never fire, and one with no status register would fire a cycle early. It also checks that masking suppresses irq_o while the status stays set, that raising the compare value does not clear a latched status, and that only a write with enable equal to 0 clears it. A design with write-one-to-clear or level status would fail these last checks.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  parameter int unsigned OFF_CNT_LO = 'h08;
  parameter int unsigned OFF_CNT_HI = 'h0C;
  parameter int unsigned OFF_CMP_LO = 'h20;
  parameter int unsigned OFF_CMP_HI = 'h24;
  parameter int unsigned OFF_CTRL   = 'h2C;

  parameter int unsigned CTL_EN   = 0;
  parameter int unsigned CTL_MASK = 1;
  parameter int unsigned CTL_STAT = 2;
endpackage

// File: rtl/sysctr_count.sv
module sysctr_count #(
  parameter int unsigned CNT_W = 56,
  parameter logic [CNT_W-1:0] CNT_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= CNT_RST;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q)); // R2
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && (&cnt_q)) |=> cnt_q == '0); // R3
endmodule

// File: rtl/sysctr_cmp.sv
module sysctr_cmp
  import sysctr_pkg::*;
#(
  parameter int unsigned CNT_W  = 56,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CMP_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cmp_lo_wr_i,
  input  logic              cmp_hi_wr_i,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CMP_W-1:0]  cmp_o,
  output logic              en_o,
  output logic              mask_o,
  output logic              stat_o,
  output logic              irq_o
);
  logic [CMP_W-1:0] cmp_q;
  logic en_q, mask_q, stat_q;
  logic hit, clr_wr;

  // only the implemented count bits take part
  assign hit    = cnt_i >= cmp_q[CNT_W-1:0];
  assign clr_wr = ctrl_wr_i && !wdata_i[CTL_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (cmp_lo_wr_i) cmp_q[DATA_W-1:0]     <= wdata_i;
      if (cmp_hi_wr_i) cmp_q[CMP_W-1:DATA_W] <= wdata_i;
      if (ctrl_wr_i) begin
        en_q   <= wdata_i[CTL_EN];
        mask_q <= wdata_i[CTL_MASK];
      end
      if (clr_wr || !en_q) stat_q <= 1'b0;
      else if (hit)        stat_q <= 1'b1;
    end
  end

  assign cmp_o  = cmp_q;
  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = stat_q & en_q & ~mask_q;

  AST_STAT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && hit && !clr_wr) |=> stat_q); // R7
  AST_STAT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> !stat_q); // R8
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr_wr) |=> stat_q); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |-> !irq_o); // R9
endmodule

// File: rtl/sysctr_rdmux.sv
module sysctr_rdmux
  import sysctr_pkg::*;
#(
  parameter int unsigned CNT_W  = 56,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CMP_W = 2 * DATA_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CMP_W-1:0]  cmp_i,
  input  logic              en_i,
  input  logic              mask_i,
  input  logic              stat_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [CMP_W-1:0] cnt_view;

  assign cnt_view = {{(CMP_W-CNT_W){1'b0}}, cnt_i};

  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_W'(OFF_CNT_LO))      rd_data_o = cnt_view[DATA_W-1:0];
    else if (addr_i == ADDR_W'(OFF_CNT_HI)) rd_data_o = cnt_view[CMP_W-1:DATA_W];
    else if (addr_i == ADDR_W'(OFF_CMP_LO)) rd_data_o = cmp_i[DATA_W-1:0];
    else if (addr_i == ADDR_W'(OFF_CMP_HI)) rd_data_o = cmp_i[CMP_W-1:DATA_W];
    else if (addr_i == ADDR_W'(OFF_CTRL)) begin
      rd_data_o[CTL_EN]   = en_i;
      rd_data_o[CTL_MASK] = mask_i;
      rd_data_o[CTL_STAT] = stat_i;
    end
  end
endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
  import sysctr_pkg::*;
#(
  parameter int unsigned CNT_W  = 56,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [CNT_W-1:0] CNT_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned CMP_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] cmp;
  logic en, mask, stat;
  logic cmp_lo_wr, cmp_hi_wr, ctrl_wr;

  // read-frame offsets decode to no write strobe
  assign cmp_lo_wr = wr_en_i && (addr_i == ADDR_W'(OFF_CMP_LO));
  assign cmp_hi_wr = wr_en_i && (addr_i == ADDR_W'(OFF_CMP_HI));
  assign ctrl_wr   = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL));

  sysctr_count #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc_en_i),
    .cnt_o (cnt)
  );

  sysctr_cmp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .cmp_lo_wr_i(cmp_lo_wr),
    .cmp_hi_wr_i(cmp_hi_wr),
    .ctrl_wr_i  (ctrl_wr),
    .wdata_i    (wr_data_i),
    .cmp_o      (cmp),
    .en_o       (en),
    .mask_o     (mask),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  sysctr_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
    .addr_i   (addr_i),
    .cnt_i    (cnt),
    .cmp_i    (cmp),
    .en_i     (en),
    .mask_i   (mask),
    .stat_i   (stat),
    .rd_data_o(rd_data_o)
  );

  AST_HI_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_CNT_HI)) |-> rd_data_o[DATA_W-1:CNT_W-DATA_W] == '0); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en && stat)); // R9
  AST_RDFRAME_NOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !inc_en_i && (addr_i == ADDR_W'(OFF_CNT_LO) || addr_i == ADDR_W'(OFF_CNT_HI)))
      |=> $stable(cnt)); // R10
endmodule

// File: tb/sysctr_top_tb.sv
module sysctr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  inc = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata [3];
  logic [2:0]  irq;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  sysctr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .inc_en_i(inc[0]), .addr_i(addr),
    .wr_en_i(wr), .wr_data_i(wdata), .rd_data_o(rdata[0]), .irq_o(irq[0]));

  sysctr_top #(.CNT_RST(56'h00_0000_FFFF_FFFC)) u_c32 (
    .clk_i(clk), .rst_ni(rst_n), .inc_en_i(inc[1]), .addr_i(addr),
    .wr_en_i(wr), .wr_data_i(wdata), .rd_data_o(rdata[1]), .irq_o(irq[1]));

  sysctr_top #(.CNT_RST(56'hFF_FFFF_FFFF_FFFE)) u_wrap (
    .clk_i(clk), .rst_ni(rst_n), .inc_en_i(inc[2]), .addr_i(addr),
    .wr_en_i(wr), .wr_data_i(wdata), .rd_data_o(rdata[2]), .irq_o(irq[2]));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int sel, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata[sel];
  endtask

  task automatic pulse(input int sel, input int n);
    @(negedge clk);
    inc[sel] = 1'b1;
    repeat (n) @(negedge clk);
    inc[sel] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(0, 8'h08, d); chk("R1 cnt lo", d, 0);
    rd_reg(0, 8'h0C, d); chk("R1 cnt hi", d, 0);
    rd_reg(0, 8'h20, d); chk("R1 cmp lo", d, 0);
    rd_reg(0, 8'h24, d); chk("R1 cmp hi", d, 0);
    rd_reg(0, 8'h2C, d); chk("R1 ctrl", d, 0);
    chk("R1 irq", 32'(irq[0]), 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    pulse(0, 25);
    rd_reg(0, 8'h08, d); chk("R2 after 25", d, 25);
    repeat (5) @(negedge clk);
    rd_reg(0, 8'h08, d); chk("R2 hold", d, 25);
  endtask

  task automatic t_carry;
    logic [31:0] d;
    rd_reg(1, 8'h08, d); chk("R4 lo before carry", d, 32'hFFFF_FFFC);
    rd_reg(1, 8'h0C, d); chk("R4 hi before carry", d, 0);
    pulse(1, 4);
    rd_reg(1, 8'h0C, d); chk("R4 hi live after carry", d, 1);
    rd_reg(1, 8'h08, d); chk("R4 lo after carry", d, 0);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    pulse(2, 1);
    rd_reg(2, 8'h0C, d); chk("R4 hi top byte zero", d, 32'h00FF_FFFF);
    rd_reg(2, 8'h08, d); chk("R3 lo all ones", d, 32'hFFFF_FFFF);
    pulse(2, 1);
    rd_reg(2, 8'h08, d); chk("R3 wrap lo", d, 0);
    rd_reg(2, 8'h0C, d); chk("R3 wrap hi", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr_reg(8'h20, 32'hDEAD_BEEF);
    wr_reg(8'h24, 32'hA512_3456);
    rd_reg(0, 8'h20, d); chk("R5 cmp lo", d, 32'hDEAD_BEEF);
    rd_reg(0, 8'h24, d); chk("R5 cmp hi", d, 32'hA512_3456);
    wr_reg(8'h2C, 32'hFFFF_FFFE);
    rd_reg(0, 8'h2C, d); chk("R6 ctrl status read-only", d, 32'h2);
    wr_reg(8'h2C, 32'h0);
    wr_reg(8'h08, 32'h1234_5678);
    wr_reg(8'h0C, 32'h0000_0077);
    rd_reg(0, 8'h08, d); chk("R10 cnt lo unchanged", d, 25);
    rd_reg(0, 8'h0C, d); chk("R10 cnt hi unchanged", d, 0);
    rd_reg(0, 8'h10, d); chk("R10 unmapped 0x10", d, 0);
    rd_reg(0, 8'h30, d); chk("R10 unmapped 0x30", d, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr_reg(8'h20, 32'd35);
    wr_reg(8'h24, 32'hFF00_0000);
    wr_reg(8'h2C, 32'h1);
    rd_reg(0, 8'h2C, d); chk("R7 no status below compare", d, 32'h1);
    pulse(0, 10);
    #1 chk("R7 irq not yet on compare edge", 32'(irq[0]), 0);
    @(negedge clk);
    #1 chk("R7 irq one edge later", 32'(irq[0]), 1);
    rd_reg(0, 8'h2C, d); chk("R6 ctrl with status", d, 32'h5);
    wr_reg(8'h20, 32'd1000);
    rd_reg(0, 8'h2C, d); chk("R8 status sticky", d, 32'h5);
    wr_reg(8'h2C, 32'h3);
    #1 chk("R9 masked irq low", 32'(irq[0]), 0);
    rd_reg(0, 8'h2C, d); chk("R9 status kept while masked", d, 32'h7);
    wr_reg(8'h2C, 32'h1);
    #1 chk("R9 unmasked irq high", 32'(irq[0]), 1);
    wr_reg(8'h2C, 32'h0);
    #1 chk("R8 irq low after enable clear", 32'(irq[0]), 0);
    rd_reg(0, 8'h2C, d); chk("R8 status cleared", d, 0);
    wr_reg(8'h2C, 32'h1);
    repeat (3) @(negedge clk);
    rd_reg(0, 8'h2C, d); chk("R7 no status when count below", d, 32'h1);
    #1 chk("R9 irq low without status", 32'(irq[0]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_carry();
    t_wrap();
    t_regs();
    t_irq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule